// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of how the most recent resolved branches went. That record picks one of several banks of small saturating counters. Inside the chosen bank, the low bits of the branch address pick one counter. The top bit of that counter is the prediction. The fetch stage presents a PC on the lookup port and gets a direction back combinationally, in the same cycle.

When a branch resolves, the execute stage presents its PC and real outcome on the update port. The block then adjusts the one counter chosen by the current history and that PC. After that it shifts the outcome into the history. With zero history bits the block becomes a plain table of counters indexed by PC. Counter storage is 2^HIST_W × CTR_W × 2^IDX_W bits, which is 8 Kbits with the default settings.

Top module: `corr_bpred`

## Requirements
- R1: After reset, the history register is zero and every counter holds the weakly not-taken value 2^(CTR_W-1)-1, which is 01 for 2-bit counters. As a result, every lookup predicts not-taken (lk_taken = 0).
- R2: lk_taken is combinational and equals the most significant bit of the counter selected by bank = history value and entry = lk_pc[IDX_W-1:0]. A value of 1 means taken.
- R3: An update with up_valid = 1 shifts up_taken (1 = taken) into bit 0 of the HIST_W-bit history. Older bits move up by one and the oldest bit is dropped. The shift takes effect at the same clock edge as the counter update.
- R4: An update changes only the counter in bank = current history at entry up_pc[IDX_W-1:0]. Every other counter in every bank keeps its value.
- R5: A counter steps up by one on a taken update and down by one on a not-taken update. It saturates at 0 and at 2^CTR_W-1.
- R6: With 2-bit counters, a counter at 3 (strongly taken) that gets one not-taken update still predicts taken. The prediction flips only after a second consecutive not-taken update to that counter.
- R7: When a lookup and an update select the same counter in the same cycle, the lookup returns the prediction from the counter's value before that update.
- R8: PC bits at and above IDX_W do not affect the lookup or the update. Two PCs that differ only in those bits share a counter.
- R9: While up_valid = 0, neither the history nor any counter changes, whatever up_pc and up_taken carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Directed sequences check the following:
- A single address is looked up under different history values, which tells bank selection apart from address indexing.
- Two addresses that differ only in their upper bits are looked up, which exposes any dependence on bits above the index.
- A long run of one outcome drives a counter into each rail, which separates correct saturation from wrap-around.
- A strongly taken counter is given a single opposite outcome, which shows the hysteresis.
- A lookup and an update hit the same counter in the same cycle, which shows whether the lookup reads the old or the new value.
- Cycles with the update strobe low but live data on the update port show that the block ignores that data.

A long mixed run of lookups and updates over a small set of aliasing addresses is then compared against a model built from the requirements. This run catches history ordering errors and updates to the wrong counter.

// File: rtl/bp_pkg.sv
// Package bp_pkg
// Shared helpers for the correlating direction predictor: the reset value of a
// counter and the saturating step. Widths up to 31 bits are assumed.
package bp_pkg;

    // Weakly not-taken value for a counter of width w: one below the midpoint.
    function automatic logic [31:0] ctr_weak_nt(int unsigned w);
        return (32'd1 << (w - 1)) - 32'd1;
    endfunction

    // Saturating step: up by one when up is set, otherwise down by one.
    function automatic logic [31:0] ctr_next(logic [31:0] cur, logic up, int unsigned w);
        logic [31:0] top;
        top = (32'd1 << w) - 32'd1;
        if (up)
            return (cur == top) ? cur : cur + 32'd1;
        else
            return (cur == 32'd0) ? cur : cur - 32'd1;
    endfunction

endpackage

// File: rtl/bp_ghist.sv
// Module bp_ghist
// Global outcome history. Each enabled cycle it shifts the new outcome into
// bit 0 and drops the oldest bit. With HIST_W = 0 it holds a constant zero of
// width 1, so the rest of the design can index with it unchanged.
module bp_ghist #(
    parameter int HIST_W = 2,
    localparam int HW = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HW-1:0] hist
);

    generate
        if (HIST_W == 0) begin : g_none
            logic unused_in;
            // No history: the value stays zero.
            assign unused_in = ^{clk, rst_n, shift_en, bit_in};
            assign hist      = '0;
        end else if (HIST_W == 1) begin : g_one
            // One-bit history: remember only the last outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= bit_in;
            end
        end else begin : g_many
            // Multi-bit history: shift the outcome into bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= {hist[HW-2:0], bit_in};
            end
        end
    endgenerate

endmodule

// File: rtl/bp_ctr_bank.sv
// Module bp_ctr_bank
// One bank of 2^IDX_W saturating counters. It has one asynchronous read port
// and one write port. A write steps the addressed counter up or down. The read
// shows the value from before any write in the same cycle. Reset loads every
// counter with the weakly not-taken value.
module bp_ctr_bank
    import bp_pkg::*;
#(
    parameter int CTR_W = 2,
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    localparam logic [CTR_W-1:0] RST_V = CTR_W'(ctr_weak_nt(CTR_W));

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] wr_val;

    // Next value of the counter being trained.
    always_comb wr_val = CTR_W'(ctr_next(32'(mem[wr_idx]), wr_up, CTR_W));

    // Counter storage: reset to weakly not-taken, otherwise train on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_V;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    // Combinational read.
    assign rd_ctr = mem[rd_idx];

endmodule

// File: rtl/corr_bpred.sv
// Module corr_bpred
// Correlating two-level direction predictor. The global history picks a
// counter bank and the low PC bits pick the entry. The lookup is
// combinational. An update trains one counter and then shifts the outcome
// into the history. The caller is assumed to present updates in the order
// the branches resolve.
module corr_bpred #(
    parameter int HIST_W = 2,
    parameter int CTR_W  = 2,
    parameter int IDX_W  = 10,
    parameter int PC_W   = 32,
    localparam int HW    = (HIST_W > 0) ? HIST_W : 1,
    localparam int NBANK = 1 << HIST_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    logic [HW-1:0]    ghist;
    logic [NBANK-1:0] bank_we;
    logic [CTR_W-1:0] bank_rd [NBANK];
    logic [CTR_W-1:0] sel_ctr;
    logic             unused_pc_hi;

    // Upper PC bits only alias entries; they feed no logic.
    generate
        if (PC_W > IDX_W) begin : g_pc_hi
            assign unused_pc_hi = ^{lk_pc[PC_W-1:IDX_W], up_pc[PC_W-1:IDX_W]};
        end else begin : g_pc_eq
            assign unused_pc_hi = 1'b0;
        end
    endgenerate

    bp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist     (ghist)
    );

    // One bank per history pattern. Only the current history's bank trains.
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign bank_we[b] = up_valid && (ghist == HW'(b));
            bp_ctr_bank #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .rd_idx (lk_pc[IDX_W-1:0]),
                .rd_ctr (bank_rd[b]),
                .wr_en  (bank_we[b]),
                .wr_idx (up_pc[IDX_W-1:0]),
                .wr_up  (up_taken)
            );
        end
    endgenerate

    // Pick the counter of the current history's bank.
    always_comb begin
        sel_ctr = bank_rd[0];
        for (int b = 0; b < NBANK; b++)
            if (ghist == HW'(b)) sel_ctr = bank_rd[b];
    end

    assign lk_taken = sel_ctr[CTR_W-1];

endmodule

// File: rtl/corr_bpred_chk.sv
// Module corr_bpred_chk
// Property checker for corr_bpred. It is attached by the bind below and
// observes the ports, the history register and the bank write enables.
module corr_bpred_chk #(
    parameter int HIST_W = 2,
    parameter int PC_W   = 32,
    localparam int HW    = (HIST_W > 0) ? HIST_W : 1,
    localparam int NBANK = 1 << HIST_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic            up_taken,
    input logic [HW-1:0]   ghist,
    input logic [NBANK-1:0] bank_we
);

    // R1
    reset_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lk_taken && ghist == '0));

    // R4
    always_comb begin
        if (rst_n) begin
            bank_wr_onehot_chk: assert ($onehot0(bank_we));
        end
    end

    // R9
    idle_hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghist));

    // R9
    idle_pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> ($stable(lk_pc) -> $stable(lk_taken)));

    generate
        if (HIST_W > 0) begin : g_hist_chk
            // R3
            hist_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> (ghist[0] == $past(up_taken)));
        end
        if (HIST_W > 1) begin : g_hist_age_chk
            // R3
            hist_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> (ghist[HW-1:1] == $past(ghist[HW-2:0])));
        end
    endgenerate

endmodule

bind corr_bpred corr_bpred_chk #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .ghist    (ghist),
    .bank_we  (bank_we)
);

// File: tb/test_corr_bpred.sv
// Bench test_corr_bpred
// Scoreboard bench. The driver applies one cycle of lookup and update. It
// pushes the prediction that a model built from the requirements expects,
// then trains the model at the clock edge. The monitor pops each expected
// item and compares it with lk_taken, away from the clock edge.
module test_corr_bpred;

    localparam int M = 2, N = 2, K = 10, PW = 32;
    localparam int NB = 1 << M, DP = 1 << K;

    typedef struct { bit exp; string tag; } item_t;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [PW-1:0] lk_pc = '0, up_pc = '0;
    logic          up_valid = 1'b0, up_taken = 1'b0;
    logic          lk_taken;

    int    checks = 0, errors = 0;
    bit    done   = 1'b0;
    item_t sb[$];

    int unsigned mdl [NB][DP];
    int unsigned mh;

    corr_bpred #(.HIST_W(M), .CTR_W(N), .IDX_W(K), .PC_W(PW)) i_corr_bpred (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    always #5 clk = ~clk;

    // Model prediction: top bit of the counter in bank mh at the low PC bits.
    function automatic bit m_pred(logic [PW-1:0] pc);
        return bit'((mdl[mh][pc[K-1:0]] >> (N - 1)) & 1);
    endfunction

    // One cycle: drive, push the expected item, then train the model at the edge.
    task automatic cyc(input logic [PW-1:0] lpc, input bit uv,
                       input logic [PW-1:0] upc, input bit ut,
                       input string tag, input bit chk);
        item_t it;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        if (chk) begin
            it.exp = m_pred(lpc); it.tag = tag;
            sb.push_back(it);
        end
        @(posedge clk);
        if (uv) begin
            if (ut && mdl[mh][upc[K-1:0]] != (1 << N) - 1) mdl[mh][upc[K-1:0]]++;
            if (!ut && mdl[mh][upc[K-1:0]] != 0)           mdl[mh][upc[K-1:0]]--;
            mh = ((mh << 1) | (ut ? 1 : 0)) & (NB - 1);
        end
    endtask

    // Monitor: pop and compare two time units after the inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (lk_taken !== it.exp) begin
                    errors++;
                    $display("FAIL %s: lk_taken=%0b expected %0b (pc=%0d)",
                             it.tag, lk_taken, it.exp, lk_pc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1ms;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < DP; i++) mdl[b][i] = (1 << (N - 1)) - 1;
        mh = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: every lookup predicts not-taken out of reset
        cyc(0, 0, 0, 0, "R1", 1);
        cyc(37, 0, 0, 0, "R1", 1);
        cyc(1023, 0, 0, 0, "R1", 1);

        // R7: lookup of the entry trained in the same cycle sees the old value
        cyc(8, 1, 8, 1, "R7", 1);
        // R3: the history is now 01, so pc 8 reads bank 1, still weak
        cyc(8, 0, 0, 0, "R3", 1);
        cyc(0, 1, 500, 0, "R3", 0);
        cyc(0, 1, 500, 0, "R3", 0);
        // R2: back at history 00, pc 8 reads the trained counter
        cyc(8, 0, 0, 0, "R2", 1);
        // R8: pc 8 + 2^K aliases to the same counter
        cyc(8 + 1024, 0, 0, 0, "R8", 1);
        cyc(32'hFFFF_FC08, 0, 0, 0, "R8", 1);
        // R4: neighbours are untouched
        cyc(9, 0, 0, 0, "R4", 1);
        cyc(500, 0, 0, 0, "R4", 1);

        // R5: saturate high under history 11
        for (int i = 0; i < 6; i++) cyc(20, 1, 20, 1, "R5", 1);
        // R6: one not-taken update keeps predicting taken
        cyc(20, 1, 20, 0, "R6", 1);
        cyc(0, 1, 99, 1, "R6", 0);
        cyc(0, 1, 99, 1, "R6", 0);
        cyc(20, 0, 0, 0, "R6", 1);
        cyc(20, 1, 20, 0, "R6", 1);
        cyc(0, 1, 99, 1, "R6", 0);
        cyc(0, 1, 99, 1, "R6", 0);
        cyc(20, 0, 0, 0, "R6", 1);
        // R5: saturate low, then one taken update
        for (int i = 0; i < 6; i++) cyc(30, 1, 30, 0, "R5", 1);
        cyc(30, 1, 30, 1, "R5", 1);
        cyc(0, 1, 77, 0, "R5", 0);
        cyc(0, 1, 77, 0, "R5", 0);
        cyc(30, 0, 0, 0, "R5", 1);

        // R9: live update data with the strobe low changes nothing
        for (int i = 0; i < 8; i++) cyc(20, 0, 20, 1, "R9", 1);
        cyc(8, 0, 8, 0, "R9", 1);
        cyc(30, 0, 30, 1, "R9", 1);

        // R2: long mixed run over aliasing addresses
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [PW-1:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {20'(lfsr[15:14]), 2'b00, 7'd0, lfsr[2:0]};
            b = {20'(lfsr[9:8]), 2'b00, 7'd0, lfsr[6:4]};
            cyc(a, lfsr[11] | lfsr[3], b, lfsr[7], "R2", 1);
        end

        cyc(0, 0, 0, 0, "R2", 0);
        @(negedge clk); #4;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule